// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address. It fetches one descriptor from a first-level table in memory. When that descriptor points on to a second-level table, it fetches a second descriptor. Three mapping granules are handled: 1 MiB sections, 64 KiB large pages and 4 KiB small pages. A walk is started by a request that carries a virtual address and a read/write flag. The walk uses the table base value that is applied on the same cycle. Descriptors are fetched through a memory read port with a request/response handshake, and only one read is outstanding at a time.

The walker handles one translation at a time and holds off further requests until the current one is answered. For each walk it produces a single-cycle result that carries the request's virtual address and direction, so a fault controller can capture them. The result also carries either a physical address with a granule code or a fault flag. The block does not cache descriptors or check permissions.

Top module: `pt_walker`

## Requirements
- R1: The first read of a walk goes to the table base with its low 14 bits cleared, plus four times virtual address bits [31:20].
- R2: A first-level descriptor whose bits [1:0] are 2'b10 ends the walk after one read. The result is a non-faulting translation with size code 2 (1 MiB) and physical address {descriptor[31:20], va[19:0]}.
- R3: A first-level descriptor whose bits [1:0] are 2'b00 or 2'b11 ends the walk after one read with the fault flag set.
- R4: A first-level descriptor whose bits [1:0] are 2'b01 causes a second read. Its address is the descriptor with bits [9:0] cleared, plus four times virtual address bits [19:12].
- R5: A second-level descriptor whose bits [1:0] are 2'b00 ends the walk with the fault flag set.
- R6: A second-level descriptor whose bits [1:0] are 2'b01 gives size code 1 (64 KiB) and physical address {descriptor[31:16], va[15:0]}.
- R7: A second-level descriptor with bit 1 set gives size code 0 (4 KiB) and physical address {descriptor[31:12], va[11:0]}, whatever bit 0 holds.
- R8: `req_ready` is low from the cycle after a request is accepted until the result cycle. A memory read request that is not accepted keeps `mem_req_valid` high and its address unchanged.
- R9: Every result, faulting or not, returns the virtual address and write flag of the request that started the walk.
- R10: After reset the walker is idle: `req_ready` is high, and no memory read or result is pending. Memory responses that arrive when no read is awaited produce no result and no read.
- R11: `res_valid` is a single-cycle pulse per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access direction, 1 = write |
| ttb | input | 32 | First-level table base, sampled with the request |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Translation fault |
| res_pa | output | 32 | Physical address (valid when not faulting) |
| res_size | output | 2 | 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB |
| res_va | output | 32 | Virtual address of the finished walk |
| res_write | output | 1 | Direction of the finished walk |

## Verification
The bound checker checks these properties on every cycle:
- the handshake rules: a stalled read stays stable, and requests are blocked while a walk is in flight;
- the single-cycle result pulse;
- the clean idle state after reset;
- the offset relation between physical and virtual address for each granule code.

The descriptor decoding can only be shown by the bench's sweep. That covers which type selects which granule, the address of each table read, the number of reads per walk and the fault outcomes. The bench sweeps many addresses over memory contents that are computed arithmetically. It also injects responses while the walker is idle, to show that they are ignored.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    WS_IDLE,
    WS_L1_ISSUE,
    WS_L1_WAIT,
    WS_L2_ISSUE,
    WS_L2_WAIT
  } walk_state_t;

  typedef enum logic [1:0] {
    L1K_FAULT,
    L1K_SECTION,
    L1K_TABLE
  } l1_kind_t;

  typedef enum logic [1:0] {
    PG_4K  = 2'd0,
    PG_64K = 2'd1,
    PG_1M  = 2'd2
  } pg_size_t;
endpackage

// File: rtl/pt_l1_decode.sv
module pt_l1_decode
  import pt_walker_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SECT_SH  = 20,
  parameter int SPG_SH   = 12,
  parameter int L2_ALIGN = 10
) (
  input  logic [AW-1:0]      desc,
  input  logic [SECT_SH-1:0] va_low,
  output l1_kind_t           kind,
  output logic [AW-1:0]      sect_pa,
  output logic [AW-1:0]      l2_addr
);
  localparam logic [AW-1:0] SECT_MASK = ~((AW'(1) << SECT_SH) - AW'(1));
  localparam logic [AW-1:0] L2_MASK   = ~((AW'(1) << L2_ALIGN) - AW'(1));

  always_comb begin
    unique case (desc[1:0])
      2'b10:   kind = L1K_SECTION;
      2'b01:   kind = L1K_TABLE;
      default: kind = L1K_FAULT;
    endcase
  end

  assign sect_pa = (desc & SECT_MASK) | AW'(va_low);
  assign l2_addr = (desc & L2_MASK) + (AW'(va_low[SECT_SH-1:SPG_SH]) << 2);
endmodule

// File: rtl/pt_l2_decode.sv
module pt_l2_decode
  import pt_walker_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LPG_SH = 16,
  parameter int SPG_SH = 12
) (
  input  logic [AW-1:0]     desc,
  input  logic [LPG_SH-1:0] va_low,
  output logic              fault,
  output logic [AW-1:0]     pa,
  output pg_size_t          size
);
  localparam logic [AW-1:0] LPG_MASK = ~((AW'(1) << LPG_SH) - AW'(1));
  localparam logic [AW-1:0] SPG_MASK = ~((AW'(1) << SPG_SH) - AW'(1));

  always_comb begin
    fault = 1'b0;
    size  = PG_4K;
    pa    = (desc & SPG_MASK) | (AW'(va_low) & ~SPG_MASK);
    if (desc[1]) begin
      size = PG_4K;
    end else if (desc[0]) begin
      size = PG_64K;
      pa   = (desc & LPG_MASK) | AW'(va_low);
    end else begin
      fault = 1'b1;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SECT_SH  = 20,
  parameter int LPG_SH   = 16,
  parameter int SPG_SH   = 12,
  parameter int L1_ALIGN = 14,
  parameter int L2_ALIGN = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_va,
  input  logic          req_write,
  input  logic [AW-1:0] ttb,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          res_valid,
  output logic          res_fault,
  output logic [AW-1:0] res_pa,
  output logic [1:0]    res_size,
  output logic [AW-1:0] res_va,
  output logic          res_write
);
  localparam logic [AW-1:0] L1_MASK = ~((AW'(1) << L1_ALIGN) - AW'(1));

  walk_state_t   st;
  logic [AW-1:0] va_q;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] l1_addr;

  l1_kind_t      l1_kind;
  logic [AW-1:0] l1_pa;
  logic [AW-1:0] l2_addr;
  logic          l2_fault;
  logic [AW-1:0] l2_pa;
  pg_size_t      l2_size;
  pg_size_t      size_q;

  assign l1_addr = (ttb & L1_MASK) + (AW'(req_va[AW-1:SECT_SH]) << 2);

  pt_l1_decode #(.AW(AW), .SECT_SH(SECT_SH), .SPG_SH(SPG_SH), .L2_ALIGN(L2_ALIGN)) u_l1 (
    .desc    (mem_rsp_data),
    .va_low  (va_q[SECT_SH-1:0]),
    .kind    (l1_kind),
    .sect_pa (l1_pa),
    .l2_addr (l2_addr)
  );

  pt_l2_decode #(.AW(AW), .LPG_SH(LPG_SH), .SPG_SH(SPG_SH)) u_l2 (
    .desc   (mem_rsp_data),
    .va_low (va_q[LPG_SH-1:0]),
    .fault  (l2_fault),
    .pa     (l2_pa),
    .size   (l2_size)
  );

  assign req_ready     = (st == WS_IDLE);
  assign mem_req_valid = (st == WS_L1_ISSUE) || (st == WS_L2_ISSUE);
  assign mem_req_addr  = addr_q;
  assign res_size      = size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= WS_IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      res_valid <= 1'b0;
      res_fault <= 1'b0;
      res_pa    <= '0;
      size_q    <= PG_4K;
      res_va    <= '0;
      res_write <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        WS_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va;
            wr_q   <= req_write;
            addr_q <= l1_addr;
            st     <= WS_L1_ISSUE;
          end
        end
        WS_L1_ISSUE: if (mem_req_ready) st <= WS_L1_WAIT;
        WS_L2_ISSUE: if (mem_req_ready) st <= WS_L2_WAIT;
        WS_L1_WAIT: begin
          if (mem_rsp_valid) begin
            if (l1_kind == L1K_TABLE) begin
              addr_q <= l2_addr;
              st     <= WS_L2_ISSUE;
            end else begin
              res_valid <= 1'b1;
              res_fault <= (l1_kind == L1K_FAULT);
              res_pa    <= (l1_kind == L1K_FAULT) ? '0 : l1_pa;
              size_q    <= PG_1M;
              res_va    <= va_q;
              res_write <= wr_q;
              st        <= WS_IDLE;
            end
          end
        end
        WS_L2_WAIT: begin
          if (mem_rsp_valid) begin
            res_valid <= 1'b1;
            res_fault <= l2_fault;
            res_pa    <= l2_fault ? '0 : l2_pa;
            size_q    <= l2_size;
            res_va    <= va_q;
            res_write <= wr_q;
            st        <= WS_IDLE;
          end
        end
        default: st <= WS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          res_valid,
  input logic          res_fault,
  input logic [AW-1:0] res_pa,
  input logic [1:0]    res_size,
  input logic [AW-1:0] res_va
);
  assert_rdy_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !mem_req_valid && !res_valid));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_no_req_while_read_R8: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  assert_word_aligned_R1: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  assert_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_section_offset_R2: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_fault && res_size == 2'd2) |-> (res_pa[19:0] == res_va[19:0]));

  assert_large_offset_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_fault && res_size == 2'd1) |-> (res_pa[15:0] == res_va[15:0]));

  assert_small_offset_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_fault && res_size == 2'd0) |-> (res_pa[11:0] == res_va[11:0]));

  assert_size_code_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_size != 2'd3));
endmodule

bind pt_walker pt_walker_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .res_valid     (res_valid),
  .res_fault     (res_fault),
  .res_pa        (res_pa),
  .res_size      (res_size),
  .res_va        (res_va)
);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [31:0] ttb = 32'h0003_C123;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid, res_fault, res_write;
  logic [31:0] res_pa, res_va;
  logic [1:0]  res_size;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_write(req_write), .ttb(ttb),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
    .res_pa(res_pa), .res_size(res_size), .res_va(res_va), .res_write(res_write)
  );

  function automatic logic [31:0] l1_word(input logic [31:0] a);
    logic [11:0] i = a[13:2];
    logic [31:0] h = a * 32'h9E37_79B1;
    case (i[1:0])
      2'd0: return {h[31:2], 2'b00};
      2'd1: return 32'h8000_0000 | ({20'd0, i} << 10) | 32'h0000_01F5;
      2'd2: return {h[31:2], 2'b10};
      default: return {h[31:2], 2'b11};
    endcase
  endfunction

  function automatic logic [31:0] l2_word(input logic [31:0] a);
    logic [7:0]  j = a[9:2];
    logic [31:0] h = a * 32'h85EB_CA6B;
    return {h[31:2], j[1:0]};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a[31] ? l2_word(a) : l1_word(a);
  endfunction

  // memory model
  int          cyc = 0;
  bit          pend = 0;
  int          lat = 0;
  logic [31:0] paddr = '0;
  bit          stray = 0;
  int          nrd = 0;
  logic [31:0] rd_addr [4];

  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      pend = 0; mem_rsp_valid = 0; mem_req_ready = 0;
    end else begin
      mem_rsp_valid = 0;
      if (stray) begin
        mem_rsp_valid = 1; mem_rsp_data = 32'h1234_5672;
      end else if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1; mem_rsp_data = mem_word(paddr); pend = 0;
        end else lat--;
      end
      mem_req_ready = !pend && (cyc % 3 != 0);
      if (!pend && mem_req_valid && mem_req_ready) begin
        pend = 1; paddr = mem_req_addr; lat = cyc % 4;
        if (nrd < 4) rd_addr[nrd] = mem_req_addr;
        nrd++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic wr);
    int n = 0;
    bit busy_ok = 1;
    logic [31:0] la, d1, l2a, d2, epa;
    nrd = 0;
    req_va = va; req_write = wr; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!res_valid && n < 200) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      n++;
    end
    chk(n < 200, "R8 walk completes", n, 200);
    chk(busy_ok, "R8 ready low while busy", 0, 1);
    chk(res_va == va && res_write == wr, "R9 va/dir returned", res_va, va);
    la = 32'h0003_C000 + {18'd0, va[31:20], 2'b00};
    d1 = l1_word(la);
    chk(rd_addr[0] == la, "R1 first read address", rd_addr[0], la);
    if (d1[1:0] == 2'b10) begin
      epa = {d1[31:20], va[19:0]};
      chk(!res_fault && res_size == 2'd2 && res_pa == epa && nrd == 1,
          "R2 section", res_pa, epa);
    end else if (d1[1:0] != 2'b01) begin
      chk(res_fault && nrd == 1, "R3 first-level fault", {31'd0, res_fault}, 1);
    end else begin
      l2a = (d1 & 32'hFFFF_FC00) + {22'd0, va[19:12], 2'b00};
      d2 = l2_word(l2a);
      chk(nrd == 2 && rd_addr[1] == l2a, "R4 second read address", rd_addr[1], l2a);
      if (d2[1]) begin
        epa = {d2[31:12], va[11:0]};
        chk(!res_fault && res_size == 2'd0 && res_pa == epa, "R7 small page", res_pa, epa);
      end else if (d2[0]) begin
        epa = {d2[31:16], va[15:0]};
        chk(!res_fault && res_size == 2'd1 && res_pa == epa, "R6 large page", res_pa, epa);
      end else begin
        chk(res_fault, "R5 second-level fault", {31'd0, res_fault}, 1);
      end
    end
    @(negedge clk);
    chk(!res_valid, "R11 single-cycle result", {31'd0, res_valid}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !res_valid, "R10 reset state",
        {29'd0, req_ready, mem_req_valid, res_valid}, 32'h4);
    // stray responses while idle
    stray = 1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!res_valid && !mem_req_valid, "R10 idle response ignored",
          {30'd0, res_valid, mem_req_valid}, 0);
    end
    stray = 0;
    @(negedge clk);
    chk(!res_valid && req_ready, "R10 still idle after stray",
        {30'd0, res_valid, req_ready}, 1);
    for (int i = 0; i < 64; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [11:0] l1i = 12'(i * 67 + j / 4);
        logic [7:0]  l2i = 8'(j * 17 + i);
        logic [11:0] off = 12'(i * 131 + j * 977);
        walk({l1i, l2i, off}, 1'((i + j) % 2));
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule